// File: doc/BRIEF.md
# Tagged Command Write Port for a Bit-Serial Pixel Engine

This block sits between a 32-bit processor bus and the controller of a bit-serial pixel array. The processor sees it as sixteen consecutive word addresses. Each write stores the data word and the four lowest address bits in a deep first-in first-out queue. Those four bits are a destination tag. The processor can therefore run ahead of the slower image controller while keeping a strict order. The processor is held off only when every queue slot is in use.

On the drain side, the block takes the oldest entry and decodes its tag. A coefficient word updates one of three staging registers. An opcode word closes a command: the current coefficients and the opcode are copied into an output slot that the controller accepts with a ready/valid handshake. A control word is delivered as a one-cycle pulse. An optional high opcode word, written before the low word, turns the next command into a 64-bit one. Commands that use only pixel memory need just the opcode write, because staged coefficients persist between commands.

Top module: `tagged_cmd_fifo`

## Requirements
- R1: After reset, `cmd_valid` and `ctrl_valid` are 0, `fifo_empty` is 1, `bus_stall` is 0, and all three staged coefficients and the pending high opcode are zero.
- R2: A write with tag 0, 1 or 2 replaces coefficient A, B or C respectively. The next command carries the most recent value of each, and the values persist across commands until they are overwritten.
- R3: A write with tag 3 (opcode low word) that has no high word pending issues a command with `cmd_wide`=0 and `cmd_op_hi`=0.
- R4: A write with tag 4 stages a high opcode word. The next tag-3 write issues a command with `cmd_wide`=1 and that high word. The staged high word is then cleared, so the command after it is narrow again.
- R5: A write with a tag from 8 to 15 raises `ctrl_valid` for exactly one cycle, with `ctrl_sel` equal to the low three tag bits and `ctrl_data` equal to the written word.
- R6: Writes with tag 5, 6 or 7 are dropped. They issue no command and no control pulse, and they change neither the coefficients nor the high-word state.
- R7: Entries take effect strictly in write order.
- R8: While `cmd_valid`=1 and `cmd_ready`=0, the command outputs hold their values. A command leaves the slot on the first clock edge where `cmd_ready`=1.
- R9: `bus_stall` is 1 exactly when the queue holds DEPTH (1024) entries. A write presented while `bus_stall`=1 is not stored.
- R10: A write accepted at clock edge t is decoded at edge t+1, so its command or control pulse is visible after edge t+1. When every entry has been consumed, `fifo_empty` is 1 again.
- R11: A control entry queued behind an unaccepted command is not delivered until that command is accepted. It is delivered on the same edge that accepts the command, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Processor write strobe |
| bus_addr | input | 4 | Low word-address bits, used as the destination tag |
| bus_wdata | input | 32 | Processor write data |
| bus_stall | output | 1 | Queue full; write not accepted |
| fifo_empty | output | 1 | Queue holds no entries |
| cmd_valid | output | 1 | Assembled command available |
| cmd_ready | input | 1 | Controller accepts the command |
| cmd_coef_a | output | 32 | Coefficient A of the command |
| cmd_coef_b | output | 32 | Coefficient B of the command |
| cmd_coef_c | output | 32 | Coefficient C of the command |
| cmd_op_lo | output | 32 | Opcode low word |
| cmd_op_hi | output | 32 | Opcode high word (zero when narrow) |
| cmd_wide | output | 1 | Command carries a 64-bit opcode |
| ctrl_valid | output | 1 | One-cycle control word strobe |
| ctrl_sel | output | 3 | Control register select (low tag bits) |
| ctrl_data | output | 32 | Control word |

## Verification
The hardest state to reach from the ports is a full queue, because the decoder normally drains entries as fast as they arrive. The bench first parks one opcode in the output slot with `cmd_ready` low. The next opcode at the head of the queue then cannot leave, and the bench keeps writing until `bus_stall` rises. It then presents a marked write during the stall and drains everything. The drain has to show the exact write order with the marked word absent. A second directed case queues a control word behind a held command, to show that the control pulse waits for the handshake.

// File: rtl/tcf_pkg.sv
// Shared widths, the queue entry type and the decoded tag kinds for the
// tagged command write port. Assumes the tag is at least four bits wide and
// that the top bit of the tag selects the control range.
package tcf_pkg;
    localparam int WORD_W   = 32;
    localparam int TAG_W    = 4;
    localparam int SEL_W    = TAG_W - 1;
    localparam int NUM_COEF = 3;
    localparam int COEF_W   = NUM_COEF * WORD_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [WORD_W-1:0] word;
    } slot_t;

    typedef enum logic [2:0] {
        K_COEF_A = 3'd0,
        K_COEF_B = 3'd1,
        K_COEF_C = 3'd2,
        K_OP_LO  = 3'd3,
        K_OP_HI  = 3'd4,
        K_CTRL   = 3'd5,
        K_DROP   = 3'd6
    } kind_e;
endpackage

// File: rtl/tcf_tag_classifier.sv
// Pure decode of a queue entry tag into its destination kind.
// Assumes: top tag bit set means control; low values 0..4 are coefficient
// and opcode words; everything else is dropped.
module tcf_tag_classifier
    import tcf_pkg::*;
(
    input  logic [TAG_W-1:0] tag,
    output kind_e            kind,
    output logic [SEL_W-1:0] ctrl_sel
);
    // Map the tag to a destination kind.
    always_comb begin
        if (tag[TAG_W-1]) begin
            kind = K_CTRL;
        end else begin
            case (tag[TAG_W-2:0])
                3'd0:    kind = K_COEF_A;
                3'd1:    kind = K_COEF_B;
                3'd2:    kind = K_COEF_C;
                3'd3:    kind = K_OP_LO;
                3'd4:    kind = K_OP_HI;
                default: kind = K_DROP;
            endcase
        end
    end

    // Control register select is the low part of the tag.
    assign ctrl_sel = tag[SEL_W-1:0];
endmodule

// File: rtl/tcf_fifo_store.sv
// Circular queue of tagged entries with a registered occupancy count.
// Assumes: DEPTH is a power of two; the consumer only pops when not empty;
// a push offered while full is refused even if a pop happens in that cycle.
module tcf_fifo_store
    import tcf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  slot_t            push_slot,
    input  logic             pop,
    output slot_t            head_slot,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = $clog2(DEPTH);

    slot_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             wr_fire;

    assign full      = (level == LVL_W'(DEPTH));
    assign empty     = (level == '0);
    assign wr_fire   = push_req && !full;
    assign head_slot = mem[rd_ptr];

    // Store an accepted entry at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_ptr] <= push_slot;
        end
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_fire) begin
                wr_ptr <= wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            case ({wr_fire, pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/tcf_cmd_assembler.sv
// Consumes queue entries one per cycle, stages coefficients and the optional
// high opcode word, and builds commands and control strobes.
// Assumes: opcode-low and control entries wait for a free output slot so
// that order between commands and control words is kept; other kinds never
// wait.
module tcf_cmd_assembler
    import tcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [WORD_W-1:0] head_word,
    input  kind_e             head_kind,
    input  logic [SEL_W-1:0]  head_sel,
    input  logic              cmd_ready,
    output logic              head_pop,
    output logic              cmd_valid,
    output logic [COEF_W-1:0] cmd_coef,
    output logic [WORD_W-1:0] cmd_op_lo,
    output logic [WORD_W-1:0] cmd_op_hi,
    output logic              cmd_wide,
    output logic              ctrl_valid,
    output logic [SEL_W-1:0]  ctrl_sel,
    output logic [WORD_W-1:0] ctrl_data
);
    logic [COEF_W-1:0] coef_stage;
    logic [WORD_W-1:0] hi_q;
    logic              hi_pend_q;
    logic              slot_free;
    logic              needs_slot;

    assign slot_free  = !cmd_valid || cmd_ready;
    assign needs_slot = (head_kind == K_OP_LO) || (head_kind == K_CTRL);
    assign head_pop   = head_valid && (!needs_slot || slot_free);

    // One staging register per coefficient, selected by its tag kind.
    for (genvar gi = 0; gi < NUM_COEF; gi++) begin : g_coef
        logic [WORD_W-1:0] stage_q;

        // Capture the coefficient word addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else if (head_pop && (head_kind == kind_e'(3'(gi)))) begin
                stage_q <= head_word;
            end
        end

        assign coef_stage[gi*WORD_W +: WORD_W] = stage_q;
    end

    // Opcode assembly, output slot handshake and control strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q       <= '0;
            hi_pend_q  <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_coef   <= '0;
            cmd_op_lo  <= '0;
            cmd_op_hi  <= '0;
            cmd_wide   <= 1'b0;
            ctrl_valid <= 1'b0;
            ctrl_sel   <= '0;
            ctrl_data  <= '0;
        end else begin
            ctrl_valid <= 1'b0;
            if (cmd_valid && cmd_ready) begin
                cmd_valid <= 1'b0;
            end
            if (head_pop) begin
                case (head_kind)
                    K_OP_HI: begin
                        hi_q      <= head_word;
                        hi_pend_q <= 1'b1;
                    end
                    K_OP_LO: begin
                        cmd_valid <= 1'b1;
                        cmd_coef  <= coef_stage;
                        cmd_op_lo <= head_word;
                        cmd_op_hi <= hi_pend_q ? hi_q : '0;
                        cmd_wide  <= hi_pend_q;
                        hi_q      <= '0;
                        hi_pend_q <= 1'b0;
                    end
                    K_CTRL: begin
                        ctrl_valid <= 1'b1;
                        ctrl_sel   <= head_sel;
                        ctrl_data  <= head_word;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tagged_cmd_fifo.sv
// Memory-mapped write port: bus writes become tagged queue entries, and the
// queue drains into coefficient, opcode and control destinations.
// Assumes: the bus holds a write while bus_stall is high; the controller
// takes commands with a ready/valid handshake and control strobes at once.
module tagged_cmd_fifo
    import tcf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [TAG_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              bus_stall,
    output logic              fifo_empty,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [WORD_W-1:0] cmd_coef_a,
    output logic [WORD_W-1:0] cmd_coef_b,
    output logic [WORD_W-1:0] cmd_coef_c,
    output logic [WORD_W-1:0] cmd_op_lo,
    output logic [WORD_W-1:0] cmd_op_hi,
    output logic              cmd_wide,
    output logic              ctrl_valid,
    output logic [SEL_W-1:0]  ctrl_sel,
    output logic [WORD_W-1:0] ctrl_data
);
    slot_t             push_slot;
    slot_t             head_slot;
    logic              head_pop;
    logic [LVL_W-1:0]  fifo_level;
    kind_e             head_kind;
    logic [SEL_W-1:0]  head_sel;
    logic [COEF_W-1:0] cmd_coef;

    assign push_slot = '{tag: bus_addr, word: bus_wdata};

    tcf_fifo_store #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (bus_wr_en),
        .push_slot (push_slot),
        .pop       (head_pop),
        .head_slot (head_slot),
        .full      (bus_stall),
        .empty     (fifo_empty),
        .level     (fifo_level)
    );

    tcf_tag_classifier class_i (
        .tag      (head_slot.tag),
        .kind     (head_kind),
        .ctrl_sel (head_sel)
    );

    tcf_cmd_assembler asm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!fifo_empty),
        .head_word  (head_slot.word),
        .head_kind  (head_kind),
        .head_sel   (head_sel),
        .cmd_ready  (cmd_ready),
        .head_pop   (head_pop),
        .cmd_valid  (cmd_valid),
        .cmd_coef   (cmd_coef),
        .cmd_op_lo  (cmd_op_lo),
        .cmd_op_hi  (cmd_op_hi),
        .cmd_wide   (cmd_wide),
        .ctrl_valid (ctrl_valid),
        .ctrl_sel   (ctrl_sel),
        .ctrl_data  (ctrl_data)
    );

    assign cmd_coef_a = cmd_coef[0*WORD_W +: WORD_W];
    assign cmd_coef_b = cmd_coef[1*WORD_W +: WORD_W];
    assign cmd_coef_c = cmd_coef[2*WORD_W +: WORD_W];
endmodule

// File: rtl/tagged_cmd_fifo_chk.sv
// Property checker for the tagged command write port, bound to the top.
// Assumes it sees the queue occupancy and the pop strobe of the top.
module tagged_cmd_fifo_chk #(
    parameter int DEPTH = 1024,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr_en,
    input logic             bus_stall,
    input logic             fifo_empty,
    input logic [LVL_W-1:0] fifo_level,
    input logic             head_pop,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_wide,
    input logic [31:0]      cmd_coef_a,
    input logic [31:0]      cmd_op_lo,
    input logic [31:0]      cmd_op_hi,
    input logic             ctrl_valid
);
    // R9: occupancy never exceeds the queue depth.
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    // R9: a write offered while stalled, with no pop, leaves occupancy alone.
    p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stall && bus_wr_en && !head_pop) |=> fifo_level == $past(fifo_level));

    // R9: occupancy moves by at most one entry per cycle.
    p_level_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == $past(fifo_level)) ||
        (fifo_level == $past(fifo_level) + LVL_W'(1)) ||
        (fifo_level + LVL_W'(1) == $past(fifo_level)));

    // R8: a refused command keeps its contents.
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_op_lo) &&
        $stable(cmd_op_hi) && $stable(cmd_coef_a) && $stable(cmd_wide));

    // R3: a narrow command carries a zero high opcode word.
    p_narrow_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_wide) |-> cmd_op_hi == '0);

    // R11: a control strobe only follows a cycle in which the slot was free.
    p_ctrl_after_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |-> $past(!cmd_valid || cmd_ready));

    // R10: nothing is consumed from an empty queue.
    p_empty_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !head_pop);
endmodule

bind tagged_cmd_fifo tagged_cmd_fifo_chk #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_en  (bus_wr_en),
    .bus_stall  (bus_stall),
    .fifo_empty (fifo_empty),
    .fifo_level (fifo_level),
    .head_pop   (head_pop),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_wide   (cmd_wide),
    .cmd_coef_a (cmd_coef_a),
    .cmd_op_lo  (cmd_op_lo),
    .cmd_op_hi  (cmd_op_hi),
    .ctrl_valid (ctrl_valid)
);

// File: tb/tagged_cmd_fifo_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for the handshake, control ordering and a full queue.
module tagged_cmd_fifo_tb_top;
    localparam int DEPTH = 1024;

    typedef struct packed {
        logic [3:0]  tag;
        logic [31:0] data;
        logic [1:0]  kind;   // 0 nothing, 1 command, 2 control strobe
        logic [31:0] ea;
        logic [31:0] eb;
        logic [31:0] ec;
        logic [31:0] elo;
        logic [31:0] ehi;
        logic        ew;
        logic [2:0]  esel;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  32'h11,   2'd1, 32'h0,  32'h0,  32'h0,  32'h11, 32'h0,  1'b0, 3'd0, 8'd1},  // R1 R3
        '{4'd0,  32'hA1,   2'd0, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd0, 8'd2},  // R2
        '{4'd1,  32'hB1,   2'd0, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd0, 8'd2},  // R2
        '{4'd2,  32'hC1,   2'd0, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd0, 8'd2},  // R2
        '{4'd3,  32'h22,   2'd1, 32'hA1, 32'hB1, 32'hC1, 32'h22, 32'h0,  1'b0, 3'd0, 8'd2},  // R2 R10
        '{4'd4,  32'h99,   2'd0, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd0, 8'd4},  // R4
        '{4'd3,  32'h33,   2'd1, 32'hA1, 32'hB1, 32'hC1, 32'h33, 32'h99, 1'b1, 3'd0, 8'd4},  // R4
        '{4'd3,  32'h44,   2'd1, 32'hA1, 32'hB1, 32'hC1, 32'h44, 32'h0,  1'b0, 3'd0, 8'd4},  // R4
        '{4'd5,  32'h55,   2'd0, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd0, 8'd6},  // R6
        '{4'd6,  32'h66,   2'd0, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd0, 8'd6},  // R6
        '{4'd7,  32'h77,   2'd0, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd0, 8'd6},  // R6
        '{4'd9,  32'hC0DE, 2'd2, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd1, 8'd5},  // R5
        '{4'd15, 32'hF0,   2'd2, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd7, 8'd5},  // R5
        '{4'd0,  32'hA2,   2'd0, 32'h0,  32'h0,  32'h0,  32'h0,  32'h0,  1'b0, 3'd0, 8'd7},  // R7
        '{4'd3,  32'h55,   2'd1, 32'hA2, 32'hB1, 32'hC1, 32'h55, 32'h0,  1'b0, 3'd0, 8'd6}   // R6 R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        cmd_ready = 1'b1;
    logic        bus_stall, fifo_empty, cmd_valid, cmd_wide, ctrl_valid;
    logic [31:0] cmd_coef_a, cmd_coef_b, cmd_coef_c, cmd_op_lo, cmd_op_hi, ctrl_data;
    logic [2:0]  ctrl_sel;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tagged_cmd_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr_en  (bus_wr_en),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_stall  (bus_stall),
        .fifo_empty (fifo_empty),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_coef_a (cmd_coef_a),
        .cmd_coef_b (cmd_coef_b),
        .cmd_coef_c (cmd_coef_c),
        .cmd_op_lo  (cmd_op_lo),
        .cmd_op_hi  (cmd_op_hi),
        .cmd_wide   (cmd_wide),
        .ctrl_valid (ctrl_valid),
        .ctrl_sel   (ctrl_sel),
        .ctrl_data  (ctrl_data)
    );

    task automatic chk(input bit ok, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", what);
        end
    endtask

    // One bus write: driven at a falling edge, taken at the next rising edge.
    task automatic bus_write(input logic [3:0] tag, input logic [31:0] data);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = tag;
        bus_wdata = data;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        chk(!cmd_valid && !ctrl_valid && fifo_empty && !bus_stall,
            $sformatf("R1 reset: actual valid=%0b ctrl=%0b empty=%0b stall=%0b expected 0 0 1 0",
                      cmd_valid, ctrl_valid, fifo_empty, bus_stall));

        // Table walk with cmd_ready held high; result appears after edge t+1 (R10).
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit   ok;
            v = VECS[i];
            bus_write(v.tag, v.data);
            @(negedge clk);
            case (v.kind)
                2'd1: ok = cmd_valid && !ctrl_valid && cmd_coef_a == v.ea &&
                           cmd_coef_b == v.eb && cmd_coef_c == v.ec &&
                           cmd_op_lo == v.elo && cmd_op_hi == v.ehi && cmd_wide == v.ew;
                2'd2: ok = ctrl_valid && !cmd_valid && ctrl_sel == v.esel && ctrl_data == v.data;
                default: ok = !cmd_valid && !ctrl_valid;
            endcase
            chk(ok, $sformatf("R%0d row %0d: actual cv=%0b xv=%0b a=%h b=%h c=%h lo=%h hi=%h w=%0b sel=%0d d=%h expected kind=%0d a=%h b=%h c=%h lo=%h hi=%h w=%0b sel=%0d",
                v.req, i, cmd_valid, ctrl_valid, cmd_coef_a, cmd_coef_b, cmd_coef_c,
                cmd_op_lo, cmd_op_hi, cmd_wide, ctrl_sel, ctrl_data,
                v.kind, v.ea, v.eb, v.ec, v.elo, v.ehi, v.ew, v.esel));
        end

        // R5: a control strobe lasts one cycle.
        bus_write(4'd8, 32'h1234);
        @(negedge clk);
        @(negedge clk);
        chk(!ctrl_valid, $sformatf("R5 pulse width: actual ctrl_valid=%0b expected 0", ctrl_valid));

        // R8: held command stays stable, leaves on ready.
        cmd_ready = 1'b0;
        bus_write(4'd3, 32'h70);
        @(negedge clk);
        chk(cmd_valid && cmd_op_lo == 32'h70,
            $sformatf("R8 issue: actual valid=%0b lo=%h expected 1 70", cmd_valid, cmd_op_lo));
        repeat (3) @(negedge clk);
        chk(cmd_valid && cmd_op_lo == 32'h70 && !cmd_wide,
            $sformatf("R8 hold: actual valid=%0b lo=%h expected 1 70", cmd_valid, cmd_op_lo));
        cmd_ready = 1'b1;
        @(negedge clk);
        chk(!cmd_valid, $sformatf("R8 accept: actual valid=%0b expected 0", cmd_valid));

        // R11: control behind a refused command waits for the handshake.
        begin
            int early;
            early = 0;
            cmd_ready = 1'b0;
            bus_write(4'd3, 32'h71);
            bus_write(4'd8, 32'hAB);
            for (int k = 0; k < 4; k++) begin
                if (ctrl_valid) early++;
                @(negedge clk);
            end
            chk(early == 0 && cmd_valid && cmd_op_lo == 32'h71,
                $sformatf("R11 wait: actual early=%0d lo=%h expected 0 71", early, cmd_op_lo));
            cmd_ready = 1'b1;
            @(negedge clk);
            chk(!cmd_valid && ctrl_valid && ctrl_sel == 3'd0 && ctrl_data == 32'hAB,
                $sformatf("R11 release: actual cv=%0b xv=%0b sel=%0d d=%h expected 0 1 0 ab",
                          cmd_valid, ctrl_valid, ctrl_sel, ctrl_data));
        end

        // R9: fill to full behind a parked command, then drain.
        begin
            int early_stall;
            int got;
            int mism;
            int dead_seen;
            early_stall = 0;
            cmd_ready = 1'b0;
            for (int k = 0; k < DEPTH + 1; k++) begin
                @(negedge clk);
                if (bus_stall) early_stall++;
                bus_wr_en = 1'b1;
                bus_addr  = 4'd3;
                bus_wdata = (k == 0) ? 32'h1000 : 32'h2000 + 32'(k - 1);
            end
            @(negedge clk);
            bus_wdata = 32'hDEAD;
            chk(early_stall == 0 && bus_stall,
                $sformatf("R9 fill: actual early=%0d stall=%0b expected 0 1", early_stall, bus_stall));
            repeat (3) @(negedge clk);
            chk(bus_stall && !fifo_empty,
                $sformatf("R9 held full: actual stall=%0b empty=%0b expected 1 0", bus_stall, fifo_empty));
            bus_wr_en = 1'b0;
            cmd_ready = 1'b1;
            got = 0;
            mism = 0;
            dead_seen = 0;
            for (int k = 0; k < DEPTH + 64; k++) begin
                if (cmd_valid) begin
                    logic [31:0] exp_lo;
                    exp_lo = (got == 0) ? 32'h1000 : 32'h2000 + 32'(got - 1);
                    if (cmd_op_lo == 32'hDEAD) dead_seen++;
                    if (cmd_op_lo != exp_lo) mism++;
                    got++;
                end
                @(negedge clk);
            end
            chk(mism == 0, $sformatf("R7 drain order: actual mismatches=%0d expected 0", mism));
            chk(got == DEPTH + 1 && dead_seen == 0,
                $sformatf("R9 stalled write dropped: actual count=%0d dead=%0d expected %0d 0",
                          got, dead_seen, DEPTH + 1));
            chk(fifo_empty && !bus_stall && !cmd_valid,
                $sformatf("R10 drained: actual empty=%0b stall=%0b valid=%0b expected 1 0 0",
                          fifo_empty, bus_stall, cmd_valid));
        end

        finish_run();
    end
endmodule